// File: doc/BRIEF.md
# Decoupled Counting Presence Filter

This block keeps an approximate record of which physical line addresses are resident in a cache. The cache controller reports every linefill and every eviction on an update port. A folded-XOR hash reduces each address to a short index, and that index selects a small saturating counter. A separate one-bit presence vector answers lookups. A lookup that returns zero proves the line is not resident, so the controller can skip an expensive search for an aliased copy. A lookup that returns one only means the line might be resident.

The presence vector is kept apart from the counter store, and each side has its own copy of the hash. The vector is written only when a counter moves between zero and non-zero. Because of this, the lookup side stays one small array with one write per crossing and one read per lookup. The counter side can sit elsewhere and be updated on its own schedule.

Top module: `cbf_tracker`

## Requirements
- R1: The index of an address is the bitwise XOR of its IDX_W-bit chunks, taken from bit 0 upward. The top chunk is zero-padded. Two addresses with equal index are indistinguishable on the lookup side.
- R2: After reset, every counter is zero and every presence bit is zero. Every lookup returns 0 and `upd_err` is low.
- R3: An accepted update with `upd_evict`=0 (allocation) increments the indexed counter. If the counter was zero, the presence bit at that index becomes 1 on the clock edge after acceptance.
- R4: An accepted update with `upd_evict`=1 (eviction) decrements the indexed counter. If the counter was one, the presence bit at that index becomes 0 on the clock edge after acceptance.
- R5: An update that leaves the counter on the same side of zero does not write the presence bit. Examples are 1 to 2 and 2 to 1.
- R6: Counters are CNT_W bits wide (default 3) and saturate at 2^CNT_W-1. An allocation on a full counter leaves it unchanged.
- R7: An eviction on a zero counter leaves the counter and the presence bit unchanged. It drives `upd_err` high for exactly the one cycle that follows acceptance.
- R8: A lookup presented with `qry_valid` high at a clock edge returns its answer on `qry_maybe`, with `qry_rvalid` high, during the following cycle. Without a lookup, `qry_rvalid` is low.
- R9: When a lookup and a presence-bit write hit the same index at the same edge, the lookup returns the bit value from before the write.
- R10: `upd_ready` is high from the first edge after reset. At most one update is accepted per edge. Cycles with `upd_valid` low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update request present |
| upd_ready | output | 1 | Update port can accept |
| upd_evict | input | 1 | 0 = allocation, 1 = eviction |
| upd_addr | input | ADDR_W | Physical line address of the update |
| upd_err | output | 1 | Eviction of a zero counter seen in the previous cycle |
| qry_valid | input | 1 | Lookup request present |
| qry_addr | input | ADDR_W | Physical address to look up |
| qry_rvalid | output | 1 | Lookup answer valid |
| qry_maybe | output | 1 | 0 = definitely absent, 1 = possibly present |

## Verification
The bench aims at the zero crossings and the points around them.
- Lookups placed in the exact cycle the vector is written show whether the old value is returned. A design that forwards the new value would report a line as present one cycle early.
- Repeated allocations past the counter ceiling, followed by matching evictions, expose a counter that wraps. Such a counter would clear the presence bit while lines are still resident, or it would miss the later underflow.
- Evictions of empty counters check that the error pulse fires and that the counter is not wrapped to full.
- Aliased addresses confirm that the hash folds every chunk, including the padded top one.
- A long randomized run over a small address pool drives many collisions, checked against a bench model.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
    typedef enum logic {
        UPD_ALLOC = 1'b0,
        UPD_EVICT = 1'b1
    } upd_op_e;
endpackage

// File: rtl/cbf_hash.sv
module cbf_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NCHUNK * IDX_W;

    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] fold [NCHUNK+1];

    assign padded  = {{(PAD_W-ADDR_W){1'b0}}, addr};
    assign fold[0] = '0;

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        assign fold[c+1] = fold[c] ^ padded[c*IDX_W +: IDX_W];
    end

    assign idx = fold[NCHUNK];
endmodule

// File: rtl/cbf_counter_bank.sv
module cbf_counter_bank
    import cbf_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  upd_op_e          op,
    input  logic [IDX_W-1:0] idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_val,
    output logic             err
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DEPTH-1:0][CNT_W-1:0] cnt;
        logic                        wr_en;
        logic [IDX_W-1:0]            wr_idx;
        logic                        wr_val;
        logic                        err;
    } bank_t;

    bank_t s_d, s_q;
    logic [CNT_W-1:0] cur;

    always_comb begin
        s_d        = s_q;
        s_d.wr_en  = 1'b0;
        s_d.wr_val = 1'b0;
        s_d.err    = 1'b0;
        s_d.wr_idx = idx;
        cur        = s_q.cnt[idx];
        if (acc) begin
            if (op == UPD_ALLOC) begin
                if (cur != CNT_MAX) begin
                    s_d.cnt[idx] = cur + CNT_ONE;
                    if (cur == '0) begin
                        s_d.wr_en  = 1'b1;
                        s_d.wr_val = 1'b1;
                    end
                end
            end else begin
                if (cur == '0) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.cnt[idx] = cur - CNT_ONE;
                    if (cur == CNT_ONE) begin
                        s_d.wr_en  = 1'b1;
                        s_d.wr_val = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_en  = s_q.wr_en;
    assign wr_idx = s_q.wr_idx;
    assign wr_val = s_q.wr_val;
    assign err    = s_q.err;
endmodule

// File: rtl/cbf_presence_vec.sv
module cbf_presence_vec #(
    parameter int IDX_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_val,
    input  logic                   qry_valid,
    input  logic [IDX_W-1:0]       qry_idx,
    output logic                   qry_rvalid,
    output logic                   qry_maybe,
    output logic [(1<<IDX_W)-1:0]  bits
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic             rvalid;
        logic             maybe;
    } vec_t;

    vec_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = qry_valid;
        s_d.maybe  = qry_valid ? s_q.bits[qry_idx] : 1'b0;
        if (wr_en) s_d.bits[wr_idx] = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign qry_rvalid = s_q.rvalid;
    assign qry_maybe  = s_q.maybe;
    assign bits       = s_q.bits;
endmodule

// File: rtl/cbf_tracker.sv
module cbf_tracker
    import cbf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    output logic              upd_ready,
    input  logic              upd_evict,
    input  logic [ADDR_W-1:0] upd_addr,
    output logic              upd_err,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_rvalid,
    output logic              qry_maybe
);
    localparam int DEPTH = 1 << IDX_W;

    logic             ready_d, ready_q;
    logic             acc;
    upd_op_e          op;
    logic [IDX_W-1:0] upd_idx, qry_idx, wr_idx;
    logic             wr_en, wr_val;
    logic [DEPTH-1:0] pres_bits;

    always_comb begin
        ready_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= ready_d;
    end

    assign upd_ready = ready_q;
    assign acc       = upd_valid && ready_q;
    assign op        = upd_evict ? UPD_EVICT : UPD_ALLOC;

    cbf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_hash_upd (
        .addr (upd_addr),
        .idx  (upd_idx)
    );

    cbf_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_hash_qry (
        .addr (qry_addr),
        .idx  (qry_idx)
    );

    cbf_counter_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .op     (op),
        .idx    (upd_idx),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .err    (upd_err)
    );

    cbf_presence_vec #(.IDX_W(IDX_W)) i_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_val     (wr_val),
        .qry_valid  (qry_valid),
        .qry_idx    (qry_idx),
        .qry_rvalid (qry_rvalid),
        .qry_maybe  (qry_maybe),
        .bits       (pres_bits)
    );
endmodule

// File: rtl/cbf_checker.sv
module cbf_checker #(
    parameter int DEPTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_valid,
    input logic             upd_ready,
    input logic             upd_evict,
    input logic             upd_err,
    input logic             qry_valid,
    input logic             qry_rvalid,
    input logic [DEPTH-1:0] pres_bits
);
    assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> qry_rvalid);

    assert_rvalid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_valid |=> !qry_rvalid);

    assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |-> $past(upd_valid && upd_ready && upd_evict));

    assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |=> $stable(pres_bits));

    assert_single_bit_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pres_bits ^ $past(pres_bits)) <= 1);

    assert_idle_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> !upd_err);
endmodule

bind cbf_tracker cbf_checker #(.DEPTH(1 << IDX_W)) i_cbf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_ready  (upd_ready),
    .upd_evict  (upd_evict),
    .upd_err    (upd_err),
    .qry_valid  (qry_valid),
    .qry_rvalid (qry_rvalid),
    .pres_bits  (pres_bits)
);

// File: tb/test_cbf_tracker.sv
module test_cbf_tracker;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = 3;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_valid = 1'b0;
    logic              upd_ready;
    logic              upd_evict = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic              upd_err;
    logic              qry_valid = 1'b0;
    logic [ADDR_W-1:0] qry_addr = '0;
    logic              qry_rvalid;
    logic              qry_maybe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int mcnt [DEPTH];
    bit mvec [DEPTH];
    bit pw_en;
    int pw_idx;
    bit pw_val;
    bit last_maybe;

    always #10 clk = ~clk;

    cbf_tracker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_cbf_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_valid  (upd_valid),
        .upd_ready  (upd_ready),
        .upd_evict  (upd_evict),
        .upd_addr   (upd_addr),
        .upd_err    (upd_err),
        .qry_valid  (qry_valid),
        .qry_addr   (qry_addr),
        .qry_rvalid (qry_rvalid),
        .qry_maybe  (qry_maybe)
    );

    function automatic int hash_of(logic [ADDR_W-1:0] a);
        int h = 0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (a[b]) h = h ^ (1 << (b % IDX_W));
        end
        return h;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit uv, bit uev, logic [ADDR_W-1:0] ua,
                        bit qv, logic [ADDR_W-1:0] qa);
        bit exp_q;
        bit exp_err;
        int i;
        upd_valid = uv;
        upd_evict = uev;
        upd_addr  = ua;
        qry_valid = qv;
        qry_addr  = qa;
        @(posedge clk);
        exp_q   = qv ? mvec[hash_of(qa)] : 1'b0;
        exp_err = 1'b0;
        if (pw_en) mvec[pw_idx] = pw_val;
        pw_en = 1'b0;
        if (uv) begin
            i = hash_of(ua);
            if (!uev) begin
                if (mcnt[i] < CMAX) begin
                    if (mcnt[i] == 0) begin
                        pw_en = 1'b1; pw_idx = i; pw_val = 1'b1;
                    end
                    mcnt[i]++;
                end
            end else begin
                if (mcnt[i] == 0) exp_err = 1'b1;
                else begin
                    if (mcnt[i] == 1) begin
                        pw_en = 1'b1; pw_idx = i; pw_val = 1'b0;
                    end
                    mcnt[i]--;
                end
            end
        end
        @(negedge clk);
        check({tag, " R8 rvalid"}, qry_rvalid, qv);
        if (qv) check({tag, " answer"}, qry_maybe, exp_q);
        check({tag, " R7 err"}, upd_err, exp_err);
        last_maybe = qry_maybe;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step("idle", 1'b0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic look(string tag, logic [ADDR_W-1:0] a, bit exp);
        step(tag, 1'b0, 1'b0, '0, 1'b1, a);
        check({tag, " directed"}, last_maybe, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a_a, a_b, a_c, a_alias, a_other;
        logic [ADDR_W-1:0] pool [8];
        int unused_seed;
        for (int k = 0; k < DEPTH; k++) begin mcnt[k] = 0; mvec[k] = 1'b0; end
        pw_en = 1'b0; pw_idx = 0; pw_val = 1'b0;
        unused_seed = $urandom(32'h5eed_c0de);

        a_a     = 32'h0000_1040;
        a_b     = 32'h00A3_7000;
        a_c     = 32'h1234_5678;
        a_alias = a_a ^ (32'h15 << IDX_W) ^ 32'h15;
        a_other = a_a ^ 32'h1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check("R2 ready", upd_ready, 1);
        check("R2 err", upd_err, 0);
        look("R2 a", a_a, 1'b0);
        look("R2 b", a_b, 1'b0);
        look("R2 c", a_c, 1'b0);

        // R10: no accept while valid low
        step("R10", 1'b0, 1'b0, a_a, 1'b0, '0);
        idle(1);
        look("R10 idle no effect", a_a, 1'b0);

        // R3 and R9: first alloc; lookup in the write cycle sees old value
        step("R3", 1'b1, 1'b0, a_a, 1'b0, '0);
        look("R9 same edge", a_a, 1'b0);
        look("R3 set", a_a, 1'b1);

        // R1: alias shares index, neighbour does not
        look("R1 alias", a_alias, 1'b1);
        look("R1 other", a_other, 1'b0);
        check("R1 hash alias", hash_of(a_alias), hash_of(a_a));

        // R5: 1->2 and 2->1 leave the bit set
        step("R5 up", 1'b1, 1'b0, a_alias, 1'b0, '0);
        idle(1);
        look("R5 after inc", a_a, 1'b1);
        step("R5 down", 1'b1, 1'b1, a_a, 1'b0, '0);
        idle(1);
        look("R5 after dec", a_a, 1'b1);

        // R4 with R9: 1->0 clears; same-edge lookup still sees 1
        step("R4", 1'b1, 1'b1, a_a, 1'b0, '0);
        look("R9 clear same edge", a_a, 1'b1);
        look("R4 cleared", a_a, 1'b0);

        // R6: saturation
        for (int k = 0; k < CMAX + 1; k++) step("R6 fill", 1'b1, 1'b0, a_b, 1'b0, '0);
        for (int k = 0; k < CMAX - 1; k++) step("R6 drain", 1'b1, 1'b1, a_b, 1'b0, '0);
        idle(1);
        look("R6 one left", a_b, 1'b1);
        step("R6 last", 1'b1, 1'b1, a_b, 1'b0, '0);
        idle(1);
        look("R6 empty", a_b, 1'b0);
        step("R6 under", 1'b1, 1'b1, a_b, 1'b0, '0);
        check("R6 saturated then underflow", upd_err, 1);

        // R7: eviction of zero counter
        step("R7 evict zero", 1'b1, 1'b1, a_c, 1'b0, '0);
        check("R7 err pulse", upd_err, 1);
        step("R7 pulse ends", 1'b0, 1'b0, '0, 1'b1, a_c);
        check("R7 err one cycle", upd_err, 0);
        check("R7 bit unchanged", last_maybe, 0);
        step("R7 alloc after", 1'b1, 1'b0, a_c, 1'b0, '0);
        step("R7 evict again", 1'b1, 1'b1, a_c, 1'b0, '0);
        check("R7 counter not wrapped", upd_err, 0);
        idle(1);
        look("R7 final", a_c, 1'b0);

        // Random mix over a small pool to force collisions
        for (int k = 0; k < 8; k++) pool[k] = $urandom;
        pool[7] = pool[0] ^ (32'h2A << IDX_W) ^ 32'h2A;
        for (int n = 0; n < 3000; n++) begin
            bit uv, ue, qv;
            uv = ($urandom % 4) != 0;
            ue = ($urandom % 2) != 0;
            qv = ($urandom % 4) != 0;
            step("R3 R4 R9 random", uv, ue, pool[$urandom % 8], qv, pool[$urandom % 8]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule